// File: doc/BRIEF.md
# Serial Receiver with Error-Tagged Receive Queue

This block turns an asynchronous serial line into characters. The line is oversampled by an enable pulse that runs at sixteen times the bit rate. Software picks the frame shape with a few configuration inputs: 5 to 8 data bits, optional even or odd parity, and one or two stop bits. Each finished character goes into a 32-entry queue. Every queue entry is 12 bits wide and holds the character together with its own framing, parity, break and overrun flags. A consumer reads the queue through a show-ahead read port. The block also reports empty, full and fill-level indications, which interrupt logic can use.

A 4-bit sticky status word collects the same error conditions across characters. A single write strobe clears it. The receiver runs only while both the global enable and the receive enable are high.

Top module: `uart_rx_core`

## Requirements
- R1: The line idles high. A frame is a low start bit, then the data bits with the least significant bit first, then the optional parity bit, then the stop bits. A 2-bit length code of 0, 1, 2 or 3 selects 5, 6, 7 or 8 data bits, and unused high character bits read as zero. Each bit is sampled 16 oversample ticks after the previous sample, whatever the tick rate is.
- R2: After the line is seen low on a tick, it is checked again 8 ticks later. If it is high by then, the event is dropped as a glitch and nothing is stored.
- R3: When parity is enabled, the parity-select input chooses even parity (1) or odd parity (0). A mismatch sets bit 9 of the entry.
- R4: When two-stop mode is set, two stop bits are checked. If any sampled stop bit is low, bit 8 (framing) is set. The receiver then waits for the line to return high before it looks for a new start bit.
- R5: If every sampled bit of a frame is low, including parity and all stop bits, exactly one entry 0x500 is stored (character 0, break bit 10, framing bit 8). Reception resumes only after the line goes high again.
- R6: If the global enable or the receive enable is low, the receiver stays idle and stores nothing.
- R7: The queue holds 32 entries. The read data shows the oldest entry, and a pop strobe removes it. The empty flag, the full flag and the fill level track the contents. A pop while the queue is empty is ignored.
- R8: If a character completes while the queue is full and no pop happens in that cycle, the character is dropped, bit 11 (overrun) is set on the newest stored entry, and the level is unchanged.
- R9: The status word holds framing in bit 0, parity in bit 1, break in bit 2 and overrun in bit 3. It collects the flags of every completed character and every overrun. Any status write clears it, but an event in the same cycle as the write is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_global | input | 1 | Global enable |
| en_rx | input | 1 | Receive enable |
| tick16 | input | 1 | Oversample pulse, 16 per bit |
| rxd | input | 1 | Serial input line |
| wlen | input | 2 | Data length code (0..3 gives 5..8 bits) |
| par_en | input | 1 | Parity checking on |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| two_stop | input | 1 | Two stop bits |
| rd_en | input | 1 | Pop the oldest entry |
| rd_data | output | 12 | Oldest entry: character plus error flags |
| rx_empty | output | 1 | Queue empty |
| rx_full | output | 1 | Queue full |
| rx_level | output | 6 | Number of stored entries |
| stat_wr | input | 1 | Status write strobe (clears) |
| rx_status | output | 4 | Sticky error status |

## Verification
The bench uses the default depth of 32 and an oversampling ratio of 16. This means 32 frames fill the queue, and a 33rd frame reaches the overrun path with a realistic number of frames. The tick divider is changed partway through the run, so the bit timing is exercised at more than one tick rate. The oversampling ratio makes the 8-tick start check and the glitch rejection line up with the half-bit point.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int ENTRY_W = 12;
  localparam int CHAR_W  = 8;
  localparam int FE_BIT  = 8;
  localparam int PE_BIT  = 9;
  localparam int BE_BIT  = 10;
  localparam int OE_BIT  = 11;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_RECOVER
  } rx_state_e;
endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               tick,
  input  logic               rxd,
  input  logic [1:0]         wlen,
  input  logic               par_en,
  input  logic               par_even,
  input  logic               two_stop,
  output logic               push_vld,
  output logic [ENTRY_W-1:0] push_data
);
  localparam int CW  = $clog2(OVS);
  localparam int MID = OVS / 2 - 1;

  rx_state_e          state_q, state_d;
  logic [CW-1:0]      cnt_q, cnt_d;
  logic [2:0]         idx_q, idx_d;
  logic [CHAR_W-1:0]  shreg_q, shreg_d;
  logic               par_q, par_d;
  logic               stop2_q, stop2_d;
  logic               fe_q, fe_d;
  logic               high_q, high_d;
  logic               push_vld_q, push_vld_d;
  logic [ENTRY_W-1:0] push_data_q, push_data_d;

  logic [2:0] last_idx;
  logic       fe_now, high_now, pe_now, at_bit;

  assign last_idx = {1'b0, wlen} + 3'd4;
  assign at_bit   = (cnt_q == CW'(OVS - 1));
  assign fe_now   = fe_q | ~rxd;
  assign high_now = high_q | rxd;
  assign pe_now   = par_en & ((^shreg_q) ^ par_q ^ ~par_even);

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    idx_d       = idx_q;
    shreg_d     = shreg_q;
    par_d       = par_q;
    stop2_d     = stop2_q;
    fe_d        = fe_q;
    high_d      = high_q;
    push_vld_d  = 1'b0;
    push_data_d = push_data_q;
    if (!active) begin
      state_d = S_IDLE;
      cnt_d   = '0;
    end else if (tick) begin
      unique case (state_q)
        S_IDLE: begin
          if (!rxd) begin
            state_d = S_START;
            cnt_d   = '0;
          end
        end
        S_START: begin
          if (cnt_q == CW'(MID)) begin
            state_d = rxd ? S_IDLE : S_DATA;
            cnt_d   = '0;
            idx_d   = '0;
            shreg_d = '0;
            par_d   = 1'b0;
            fe_d    = 1'b0;
            high_d  = 1'b0;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        S_DATA: begin
          if (at_bit) begin
            shreg_d[idx_q] = rxd;
            high_d         = high_now;
            cnt_d          = '0;
            if (idx_q == last_idx) begin
              state_d = par_en ? S_PAR : S_STOP;
              stop2_d = two_stop;
            end else begin
              idx_d = idx_q + 3'd1;
            end
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        S_PAR: begin
          if (at_bit) begin
            par_d   = rxd;
            high_d  = high_now;
            cnt_d   = '0;
            state_d = S_STOP;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        S_STOP: begin
          if (at_bit) begin
            cnt_d  = '0;
            fe_d   = fe_now;
            high_d = high_now;
            if (stop2_q) begin
              stop2_d = 1'b0;
            end else begin
              push_vld_d = 1'b1;
              if (!high_now) begin
                push_data_d = '0;
                push_data_d[BE_BIT] = 1'b1;
                push_data_d[FE_BIT] = 1'b1;
              end else begin
                push_data_d = {1'b0, 1'b0, pe_now, fe_now, shreg_q};
              end
              state_d = fe_now ? S_RECOVER : S_IDLE;
            end
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
        S_RECOVER: begin
          if (rxd) state_d = S_IDLE;
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      cnt_q       <= '0;
      idx_q       <= '0;
      shreg_q     <= '0;
      par_q       <= 1'b0;
      stop2_q     <= 1'b0;
      fe_q        <= 1'b0;
      high_q      <= 1'b0;
      push_vld_q  <= 1'b0;
      push_data_q <= '0;
    end else begin
      state_q     <= state_d;
      cnt_q       <= cnt_d;
      idx_q       <= idx_d;
      shreg_q     <= shreg_d;
      par_q       <= par_d;
      stop2_q     <= stop2_d;
      fe_q        <= fe_d;
      high_q      <= high_d;
      push_vld_q  <= push_vld_d;
      push_data_q <= push_data_d;
    end
  end

  assign push_vld  = push_vld_q;
  assign push_data = push_data_q;

  AST_BREAK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (push_vld_q && push_data_q[BE_BIT]) |-> (push_data_q[FE_BIT] && push_data_q[CHAR_W-1:0] == '0)); // R5
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (state_q == S_IDLE && !push_vld_q)); // R6
  AST_GLITCH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tick && state_q == S_START && cnt_q == CW'(MID) && rxd) |=> state_q == S_IDLE); // R2
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int W     = ENTRY_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [W-1:0]               wr_data,
  input  logic                       rd_en,
  output logic [W-1:0]               rd_data,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       ovr_evt
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    mem [DEPTH];
  logic [AW-1:0]   wptr_q, wptr_d, rptr_q, rptr_d, newest;
  logic [CNTW-1:0] count_q, count_d;
  logic            push_ok, pop_ok;

  assign empty   = (count_q == '0);
  assign full    = (count_q == CNTW'(DEPTH));
  assign pop_ok  = rd_en && !empty;
  assign push_ok = wr_en && (!full || pop_ok);
  assign ovr_evt = wr_en && full && !pop_ok;
  assign newest  = wptr_q - AW'(1);

  always_comb begin
    wptr_d  = push_ok ? wptr_q + AW'(1) : wptr_q;
    rptr_d  = pop_ok  ? rptr_q + AW'(1) : rptr_q;
    count_d = count_q;
    if (push_ok && !pop_ok)      count_d = count_q + CNTW'(1);
    else if (!push_ok && pop_ok) count_d = count_q - CNTW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
      count_q <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok)      mem[wptr_q]         <= wr_data;
    else if (ovr_evt) mem[newest][OE_BIT] <= 1'b1;
  end

  assign rd_data = mem[rptr_q];
  assign level   = count_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> $stable(count_q)); // R8
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty && !wr_en) |=> count_q == '0); // R7
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int OVS   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en_global,
  input  logic                       en_rx,
  input  logic                       tick16,
  input  logic                       rxd,
  input  logic [1:0]                 wlen,
  input  logic                       par_en,
  input  logic                       par_even,
  input  logic                       two_stop,
  input  logic                       rd_en,
  output logic [ENTRY_W-1:0]         rd_data,
  output logic                       rx_empty,
  output logic                       rx_full,
  output logic [$clog2(DEPTH+1)-1:0] rx_level,
  input  logic                       stat_wr,
  output logic [3:0]                 rx_status
);
  logic [1:0]         rst_sync_q;
  logic               rst_i_n;
  logic               push_vld, ovr_evt;
  logic [ENTRY_W-1:0] push_data;
  logic [3:0]         stat_q, stat_d, stat_new;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  uart_rx_frame #(.OVS(OVS)) u_frame (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .active   (en_global & en_rx),
    .tick     (tick16),
    .rxd      (rxd),
    .wlen     (wlen),
    .par_en   (par_en),
    .par_even (par_even),
    .two_stop (two_stop),
    .push_vld (push_vld),
    .push_data(push_data)
  );

  uart_rx_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .wr_en  (push_vld),
    .wr_data(push_data),
    .rd_en  (rd_en),
    .rd_data(rd_data),
    .empty  (rx_empty),
    .full   (rx_full),
    .level  (rx_level),
    .ovr_evt(ovr_evt)
  );

  always_comb begin
    stat_new = {ovr_evt,
                push_vld & push_data[BE_BIT],
                push_vld & push_data[PE_BIT],
                push_vld & push_data[FE_BIT]};
    stat_d = (stat_wr ? 4'b0000 : stat_q) | stat_new;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) stat_q <= 4'b0000;
    else          stat_q <= stat_d;
  end
  assign rx_status = stat_q;

  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_i_n)
    (stat_wr && !push_vld) |=> stat_q == 4'b0000); // R9
  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_i_n)
    !stat_wr |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R9
endmodule

// File: tb/sim_uart_rx_core.sv
module sim_uart_rx_core;
  localparam int DEPTH = 32;

  logic        clk, rst_n, en_global, en_rx, tick16, rxd;
  logic [1:0]  wlen;
  logic        par_en, par_even, two_stop, rd_en, stat_wr;
  logic [11:0] rd_data;
  logic        rx_empty, rx_full;
  logic [5:0]  rx_level;
  logic [3:0]  rx_status;

  int n_chk = 0, n_bad = 0, tdiv = 1, tcnt = 0;
  bit mon_on = 0;
  logic mon_rd = 0, man_rd = 0;
  logic [11:0] expq[$];
  string       tagq[$];

  assign rd_en = mon_rd | man_rd;

  uart_rx_core #(.DEPTH(DEPTH), .OVS(16)) u0 (
    .clk(clk), .rst_n(rst_n), .en_global(en_global), .en_rx(en_rx),
    .tick16(tick16), .rxd(rxd), .wlen(wlen), .par_en(par_en),
    .par_even(par_even), .two_stop(two_stop), .rd_en(rd_en),
    .rd_data(rd_data), .rx_empty(rx_empty), .rx_full(rx_full),
    .rx_level(rx_level), .stat_wr(stat_wr), .rx_status(rx_status)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  initial begin
    tick16 = 0;
    forever begin
      @(negedge clk);
      tcnt++;
      if (tcnt >= tdiv) begin tick16 = 1; tcnt = 0; end
      else tick16 = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      mon_rd = 0;
      if (mon_on && rst_n && !rx_empty) begin
        if (expq.size() == 0) chk(0, "R7 unexpected entry", int'(rd_data), 0);
        else begin
          automatic logic [11:0] e = expq.pop_front();
          automatic string t = tagq.pop_front();
          chk(rd_data == e, t, int'(rd_data), int'(e));
        end
        mon_rd = 1;
      end
    end
  end

  task automatic wait_ticks(input int n);
    repeat (n) begin
      do @(posedge clk); while (!tick16);
    end
  endtask

  task automatic drive_bit(input logic v);
    rxd = v;
    wait_ticks(16);
    @(negedge clk);
  endtask

  task automatic idle_gap();
    rxd = 1;
    wait_ticks(24);
    @(negedge clk);
  endtask

  function automatic int nbits();
    return int'(wlen) + 5;
  endfunction

  task automatic push_exp(input logic [11:0] e, input string t);
    if (!mon_on && expq.size() == DEPTH) expq[DEPTH-1][11] = 1'b1;
    else begin expq.push_back(e); tagq.push_back(t); end
  endtask

  task automatic send(input logic [7:0] d, input bit bad_par, input bit bad_stop,
                      input bit track, input string t);
    logic [7:0] m;
    logic p;
    m = d & 8'((1 << nbits()) - 1);
    if (track) push_exp({2'b00, bad_par & par_en, bad_stop, m}, t);
    drive_bit(1'b0);
    for (int i = 0; i < nbits(); i++) drive_bit(m[i]);
    if (par_en) begin
      p = par_even ? ^m : ~^m;
      drive_bit(p ^ bad_par);
    end
    drive_bit(~bad_stop);
    if (two_stop) drive_bit(1'b1);
    idle_gap();
  endtask

  task automatic send_break(input string t);
    int nb;
    push_exp(12'h500, t);
    nb = 1 + nbits() + int'(par_en) + 1 + int'(two_stop) + 1;
    rxd = 0;
    for (int i = 0; i < nb; i++) drive_bit(1'b0);
    idle_gap();
  endtask

  task automatic drain();
    int guard = 0;
    while (expq.size() != 0 && guard < 2000) begin @(negedge clk); guard++; end
    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R7 drain", expq.size(), 0);
  endtask

  task automatic clr_stat();
    @(negedge clk); stat_wr = 1;
    @(negedge clk); stat_wr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; en_global = 1; en_rx = 1; rxd = 1; wlen = 2'd3;
    par_en = 0; par_even = 0; two_stop = 0; stat_wr = 0;
    repeat (5) @(negedge clk);
    chk(rx_empty == 1, "R7 reset empty", rx_empty, 1);
    chk(rx_full == 0, "R7 reset full", rx_full, 0);
    chk(rx_level == 0, "R7 reset level", rx_level, 0);
    chk(rx_status == 0, "R9 reset status", rx_status, 0);
    rst_n = 1;
    repeat (6) @(negedge clk);
    mon_on = 1;

    // R1: 8 data bits, several patterns
    send(8'h55, 0, 0, 1, "R1 8N1 55");
    send(8'hA3, 0, 0, 1, "R1 8N1 A3");
    send(8'h00, 0, 0, 1, "R1 8N1 00");
    send(8'hFF, 0, 0, 1, "R1 8N1 FF");
    // R1: shorter lengths
    wlen = 2'd0; send(8'hFF, 0, 0, 1, "R1 5 bits");
    wlen = 2'd1; send(8'hC5, 0, 0, 1, "R1 6 bits");
    wlen = 2'd2; send(8'hD9, 0, 0, 1, "R1 7 bits");
    wlen = 2'd3;
    // R1: slower tick rate
    tdiv = 3;
    send(8'h3C, 0, 0, 1, "R1 tick div3");
    tdiv = 1;
    drain();

    // R3: parity
    clr_stat();
    par_en = 1; par_even = 1;
    send(8'h37, 0, 0, 1, "R3 even ok");
    send(8'h37, 1, 0, 1, "R3 even bad");
    drain();
    chk(rx_status == 4'b0010, "R9 parity sticky", rx_status, 4'b0010);
    par_even = 0;
    send(8'h81, 0, 0, 1, "R3 odd ok");
    send(8'h81, 1, 0, 1, "R3 odd bad");
    par_en = 0;

    // R4: stop bits
    two_stop = 1;
    send(8'h5A, 0, 0, 1, "R4 two stop ok");
    send(8'h5A, 0, 1, 1, "R4 two stop bad");
    two_stop = 0;
    send(8'h96, 0, 1, 1, "R4 one stop bad");
    send(8'h69, 0, 0, 1, "R4 after framing");
    drain();
    chk(rx_status == 4'b0011, "R9 framing+parity sticky", rx_status, 4'b0011);
    clr_stat();
    chk(rx_status == 4'b0000, "R9 write clears", rx_status, 0);

    // R5: break
    send_break("R5 break entry");
    send(8'h24, 0, 0, 1, "R5 after break");
    drain();
    chk(rx_status == 4'b0101, "R9 break status", rx_status, 4'b0101);
    clr_stat();

    // R2: glitch
    mon_on = 0;
    rxd = 0; wait_ticks(4); @(negedge clk); rxd = 1;
    wait_ticks(200); @(negedge clk);
    chk(rx_empty == 1, "R2 glitch dropped", rx_empty, 1);

    // R6: enables
    en_rx = 0;
    send(8'h11, 0, 0, 0, "");
    chk(rx_level == 0, "R6 rx enable off", rx_level, 0);
    en_rx = 1; en_global = 0;
    send(8'h22, 0, 0, 0, "");
    chk(rx_level == 0, "R6 global enable off", rx_level, 0);
    en_global = 1;

    // R7: pop on empty ignored
    @(negedge clk); man_rd = 1; @(negedge clk); man_rd = 0;
    chk(rx_level == 0 && rx_empty == 1, "R7 pop on empty", rx_level, 0);

    // R7/R8: fill and overrun
    for (int i = 0; i < DEPTH; i++) send(8'(i + 8'h40), 0, 0, 1, "R8 fill entry");
    chk(rx_full == 1, "R7 full flag", rx_full, 1);
    chk(rx_level == DEPTH, "R7 level full", rx_level, DEPTH);
    chk(rx_status == 0, "R9 no error while filling", rx_status, 0);
    send(8'hEE, 0, 0, 1, "R8 dropped");
    chk(rx_level == DEPTH, "R8 level unchanged", rx_level, DEPTH);
    chk(rx_status == 4'b1000, "R8 overrun status", rx_status, 4'b1000);
    mon_on = 1;
    drain();
    chk(rx_empty == 1 && rx_level == 0, "R7 empty after drain", rx_level, 0);

    send(8'h42, 0, 0, 1, "R7 after drain");
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule